// File: doc/BRIEF.md
# One-Hot Pointer Dual-Clock Sample FIFO

This block carries a stream of samples from an input data-clock domain into an output converter-clock domain through a small circular buffer. One sample is written on every write-clock edge and one is read on every read-clock edge. Both clocks run at the same rate with an arbitrary phase. Each side tracks its position with a rotating one-hot register instead of a binary counter. Such a register has no means of recovery: after a general reset both pointers hold all zeros, nothing is written or read, and the block stays stalled until a pointer event loads a single set bit.

A SYNC event, taken in the write domain, places the write pointer at entry 0. An ALIGN event, taken in the read domain, places the read pointer half the depth away. A configuration bit lets SYNC drive both pointers. SYNC can come from an input pin or from a two-write software sequence on a small configuration port. The read side watches a two-flop synchronised copy of the write pointer. It raises a warning when the pointers are two entries apart and an alarm when they collide or when either pointer is not one-hot.

Top module: `onehot_sample_fifo`

## Requirements
- R1: After a general reset, and until a pointer event arrives, the FIFO writes nothing, `rd_data` holds 0, and `alarm` is 1 from the second read-clock edge after reset is released.
- R2: `sync_in` sampled high on a write-clock edge stores that edge's `wr_data` in entry 0. Following samples go to entries 1, 2, … one per edge and wrap after DEPTH-1.
- R3: `align_in` sampled high on a read-clock edge loads `rd_data` with entry DEPTH/2 on that edge. Each following read-clock edge outputs the next entry, wrapping modulo DEPTH.
- R4: With the sync-only bit (`cfg_wdata[0]`) set, a SYNC event taken on write edge n also performs the R3 read reinitialisation on the third read-clock edge after write edge n. It does this without any ALIGN.
- R5: A configuration write with `cfg_wdata[1]`=1 (software-sync enable) and `cfg_wdata[2]`=1 (software-sync bit), when the stored software-sync bit is 0, is a SYNC event on that same write edge.
- R6: A configuration write that sets the software-sync bit while the enable bit of that write is 0, or while the stored software-sync bit is already 1, produces no SYNC event.
- R7: `warn` is 1 when the pointers are two entries apart in either direction and neither alarm condition holds. Data keeps flowing unchanged while it is set. It settles within four read cycles of the pointers advancing steadily.
- R8: `alarm` is 1 when the read pointer and the synchronised write pointer select the same entry, or when either of them is not one-hot.
- R9: A SYNC repeated every multiple of DEPTH write cycles lands on the entry already in use and leaves the output stream unbroken.
- R10: A general reset clears `rd_data`, `warn` and `alarm` while it is held. It also clears every configuration bit, so after reset a SYNC moves only the write pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write (data) clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_data | input | DATA_W | Sample written on each write-clock edge |
| sync_in | input | 1 | SYNC event pulse, write domain |
| cfg_we | input | 1 | Configuration write strobe, write domain |
| cfg_wdata | input | 3 | Bit0 sync-only, bit1 software-sync enable, bit2 software-sync bit |
| rd_clk | input | 1 | Read (converter) clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| align_in | input | 1 | ALIGN event pulse, read domain |
| rd_data | output | DATA_W | Registered sample read on each read-clock edge |
| warn | output | 1 | Pointers two entries apart |
| alarm | output | 1 | Pointer collision or pointer not one-hot |

## Verification
The bench keeps a behavioural model of the buffer contents and of both pointer positions, and compares every read against it. An offset error in the SYNC or ALIGN target, or a pointer that leaves reset running instead of stuck, shows up as wrong samples. It places ALIGN at chosen distances after SYNC to reach the nominal, two-apart and colliding spacings. A flag comparison that is off by one entry, or a warning that stalls data, is then reported. It issues SYNC every DEPTH cycles, and the software-sync writes with a missing enable or an already-set bit, so a design that reinitialises on a level or a redundant request visibly breaks the stream. It also resets with sync-only set, which catches a configuration bit that survives reset.

// File: rtl/ohf_pkg.sv
package ohf_pkg;
  localparam int CFG_W      = 3;
  localparam int CFG_SONLY  = 0;  // SYNC also reinitialises the read pointer
  localparam int CFG_SWEN   = 1;  // software sync enable
  localparam int CFG_SWSYNC = 2;  // software sync request bit
endpackage

// File: rtl/ohf_sync.sv
module ohf_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else if (g == 0) stg[g] <= d;
        else stg[g] <= stg[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ohf_dpram.sv
module ohf_dpram #(
  parameter int DW    = 14,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_rst) rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ohf_wr_ctrl.sv
module ohf_wr_ctrl
  import ohf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             wr_clk,
  input  logic             wr_rst,
  input  logic             sync_in,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [DEPTH-1:0] wptr,
  output logic             sync_tgl,
  output logic             sync_only,
  output logic             we,
  output logic [AW-1:0]    waddr
);
  localparam logic [DEPTH-1:0] WR_NEXT = DEPTH'(2);

  logic swsync_q, sw_evt, sync_evt;
  logic [AW-1:0] widx;

  function automatic logic [AW-1:0] oh2idx(input logic [DEPTH-1:0] p);
    logic [AW-1:0] r;
    r = '0;
    for (int i = 0; i < DEPTH; i++) if (p[i]) r = r | AW'(i);
    return r;
  endfunction

  assign sw_evt   = cfg_we & cfg_wdata[CFG_SWEN] & cfg_wdata[CFG_SWSYNC] & ~swsync_q;
  assign sync_evt = sync_in | sw_evt;
  assign widx     = oh2idx(wptr);
  assign we       = sync_evt | (|wptr);
  assign waddr    = sync_evt ? '0 : widx;

  always_ff @(posedge wr_clk) begin
    if (wr_rst) begin
      wptr      <= '0;
      sync_tgl  <= 1'b0;
      sync_only <= 1'b0;
      swsync_q  <= 1'b0;
    end else begin
      if (cfg_we) begin
        sync_only <= cfg_wdata[CFG_SONLY];
        swsync_q  <= cfg_wdata[CFG_SWSYNC];
      end
      if (sync_evt) wptr <= WR_NEXT;
      else          wptr <= {wptr[DEPTH-2:0], wptr[DEPTH-1]};
      sync_tgl <= sync_tgl ^ sync_evt;
    end
  end

  AST_WPTR_ONEHOT0: assert property (@(posedge wr_clk) disable iff (wr_rst)
    $onehot0(wptr)); // R1
  AST_SYNC_TO_ENTRY0: assert property (@(posedge wr_clk) disable iff (wr_rst)
    sync_in |=> (wptr == WR_NEXT)); // R2
  AST_SW_NEEDS_EN: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (cfg_we && !cfg_wdata[CFG_SWEN] && !sync_in && wptr == '0) |=> (wptr == '0)); // R6
endmodule

// File: rtl/ohf_rd_ctrl.sv
module ohf_rd_ctrl #(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             rd_clk,
  input  logic             rd_rst,
  input  logic             align_in,
  input  logic             sync_tgl_w,
  input  logic             sync_only_w,
  input  logic [DEPTH-1:0] wptr_w,
  output logic             re,
  output logic [AW-1:0]    raddr,
  output logic             warn,
  output logic             alarm
);
  localparam int HALF = DEPTH / 2;
  localparam logic [DEPTH-1:0] RD_NEXT = DEPTH'(1) << ((HALF + 1) % DEPTH);
  localparam logic [AW-1:0]    HALF_A  = AW'(HALF);

  logic [DEPTH-1:0] rptr, wptr_s;
  logic sonly_s, tgl_s, tgl_q, reinit, bad, near;

  function automatic logic [AW-1:0] oh2idx(input logic [DEPTH-1:0] p);
    logic [AW-1:0] r;
    r = '0;
    for (int i = 0; i < DEPTH; i++) if (p[i]) r = r | AW'(i);
    return r;
  endfunction

  function automatic logic [DEPTH-1:0] rotl1(input logic [DEPTH-1:0] p);
    return {p[DEPTH-2:0], p[DEPTH-1]};
  endfunction

  ohf_sync #(.W(DEPTH + 2), .STAGES(2)) u_sync (
    .clk(rd_clk), .rst(rd_rst),
    .d({sync_only_w, sync_tgl_w, wptr_w}),
    .q({sonly_s, tgl_s, wptr_s})
  );

  assign reinit = align_in | (sonly_s & (tgl_s ^ tgl_q));
  assign re     = reinit | (|rptr);
  assign raddr  = reinit ? HALF_A : oh2idx(rptr);

  assign bad  = !$onehot(rptr) || !$onehot(wptr_s) || (|(rptr & wptr_s));
  assign near = ({rptr[DEPTH-3:0], rptr[DEPTH-1:DEPTH-2]} == wptr_s) ||
                ({rptr[1:0], rptr[DEPTH-1:2]} == wptr_s);

  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      rptr  <= '0;
      tgl_q <= 1'b0;
      warn  <= 1'b0;
      alarm <= 1'b0;
    end else begin
      tgl_q <= tgl_s;
      rptr  <= reinit ? RD_NEXT : rotl1(rptr);
      alarm <= bad;
      warn  <= near & ~bad;
    end
  end

  AST_ALIGN_REINIT: assert property (@(posedge rd_clk) disable iff (rd_rst)
    align_in |=> (rptr == RD_NEXT)); // R3
  AST_RPTR_STUCK: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rptr == '0 && !reinit) |=> (rptr == '0)); // R1
  AST_RPTR_ROTATES: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (!align_in && !sonly_s) |=> (rptr == rotl1($past(rptr)))); // R4
  AST_ZERO_PTR_ALARM: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rptr == '0) |=> alarm); // R8
endmodule

// File: rtl/onehot_sample_fifo.sv
module onehot_sample_fifo
  import ohf_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int DEPTH  = 8
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sync_in,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              align_in,
  output logic [DATA_W-1:0] rd_data,
  output logic              warn,
  output logic              alarm
);
  localparam int AW = $clog2(DEPTH);

  logic [DEPTH-1:0] wptr;
  logic sync_tgl, sync_only, we, re;
  logic [AW-1:0] waddr, raddr;

  ohf_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .sync_in(sync_in),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .wptr(wptr), .sync_tgl(sync_tgl), .sync_only(sync_only),
    .we(we), .waddr(waddr)
  );

  ohf_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .rd_clk(rd_clk), .rd_rst(rd_rst), .align_in(align_in),
    .sync_tgl_w(sync_tgl), .sync_only_w(sync_only), .wptr_w(wptr),
    .re(re), .raddr(raddr), .warn(warn), .alarm(alarm)
  );

  ohf_dpram #(.DW(DATA_W), .DEPTH(DEPTH)) u_ram (
    .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .re(re), .raddr(raddr),
    .rdata(rd_data)
  );
endmodule

// File: tb/sim_onehot_sample_fifo.sv
module sim_onehot_sample_fifo;
  localparam int DW = 14;
  localparam int DEPTH = 8;
  localparam int HALF = DEPTH / 2;

  logic wr_clk = 1'b0, rd_clk = 1'b1;
  logic rst = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic sync_in = 1'b0, cfg_we = 1'b0, align_in = 1'b0;
  logic [2:0] cfg_wdata = '0;
  logic [DW-1:0] rd_data;
  logic warn, alarm;

  // 125 MHz on both sides; read edges trail write edges by half a period
  initial forever #4 wr_clk = ~wr_clk;
  initial forever #4 rd_clk = ~rd_clk;

  onehot_sample_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
    .wr_clk(wr_clk), .wr_rst(rst), .wr_data(wr_data), .sync_in(sync_in),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .rd_clk(rd_clk), .rd_rst(rst),
    .align_in(align_in), .rd_data(rd_data), .warn(warn), .alarm(alarm)
  );

  int tests = 0, fails = 0;
  bit finished = 0;
  string req = "R1";

  // behavioural model
  int wpos = -1, rpos = -1, settle = 0;
  logic [DW-1:0] mmem [DEPTH];
  bit mval [DEPTH];
  logic [DW-1:0] exp_rd = '0, cnt = '0, prev_rd = '0;
  bit exp_ok = 1, prev_ok = 0, chk_seq = 0;
  bit m_sonly = 0, m_swq = 0, sev0 = 0, sev1 = 0, sev2 = 0;

  task automatic check(input bit ok, input string r, input string what,
                       input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, expv);
    end
  endtask

  task automatic cyc(input bit s, input bit we, input logic [2:0] d, input bit al);
    bit sev, rre;
    int dd;
    bit ea, ew;
    sync_in = s; cfg_we = we; cfg_wdata = d; align_in = al; wr_data = cnt;
    @(posedge wr_clk); #2;
    sev = s | (we & d[1] & d[2] & ~m_swq);
    if (we) begin m_swq = d[2]; m_sonly = d[0]; end
    if (sev) begin
      mmem[0] = cnt; mval[0] = 1; wpos = 1; settle = 0;
    end else if (wpos >= 0) begin
      mmem[wpos] = cnt; mval[wpos] = 1; wpos = (wpos + 1) % DEPTH;
    end
    sev2 = sev1; sev1 = sev0; sev0 = sev;
    sync_in = 0; cfg_we = 0; cnt = cnt + 1'b1;
    @(posedge rd_clk); #2;
    rre = al | (m_sonly & sev2);
    if (rre) begin
      exp_ok = mval[HALF]; exp_rd = mmem[HALF];
      rpos = (HALF + 1) % DEPTH; settle = 0;
    end else if (rpos >= 0) begin
      exp_ok = mval[rpos]; exp_rd = mmem[rpos];
      rpos = (rpos + 1) % DEPTH;
    end
    if (exp_ok) check(rd_data === exp_rd, req, "rd_data", int'(rd_data), int'(exp_rd));
    if (chk_seq && prev_ok)  // R9 unbroken stream
      check(rd_data === prev_rd + 1'b1, "R9", "stream step",
            int'(rd_data), int'(prev_rd + 1'b1));
    prev_rd = rd_data; prev_ok = exp_ok;
    settle++;
    if (settle >= 4) begin
      if (wpos < 0 || rpos < 0) begin ea = 1; ew = 0; end
      else begin
        dd = ((rpos - wpos + 1) % DEPTH + DEPTH) % DEPTH;
        ea = (dd == 0); ew = (dd == 2 || dd == DEPTH - 2);
      end
      check(alarm === ea, "R8", "alarm", int'(alarm), int'(ea));
      check(warn === ew, "R7", "warn", int'(warn), int'(ew));
    end
    align_in = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 3'b000, 0);
  endtask

  task automatic wait_wpos(input int p);
    while (wpos != p) cyc(0, 0, 3'b000, 0);
  endtask

  task automatic do_reset();
    rst = 1; sync_in = 0; cfg_we = 0; align_in = 0;
    repeat (3) @(posedge rd_clk);
    #2;
    check(rd_data === '0, "R10", "rd_data in reset", int'(rd_data), 0);
    check(warn === 1'b0, "R10", "warn in reset", int'(warn), 0);
    check(alarm === 1'b0, "R10", "alarm in reset", int'(alarm), 0);
    rst = 0;
    wpos = -1; rpos = -1; settle = 0; m_sonly = 0; m_swq = 0;
    sev0 = 0; sev1 = 0; sev2 = 0; exp_rd = '0; exp_ok = 1; prev_ok = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    fails++; tests++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mval[i] = 0;
    // R1: stuck pointers after reset
    do_reset();
    req = "R1";
    idle(8);
    check(alarm === 1'b1, "R1", "alarm while stuck", int'(alarm), 1);
    check(rd_data === '0, "R1", "rd_data while stuck", int'(rd_data), 0);

    // R2 R3: SYNC and ALIGN together give the half-depth spacing
    req = "R2 R3";
    cyc(1, 0, 3'b000, 1);
    idle(20);
    check(alarm === 1'b0 && warn === 1'b0, "R3", "flags nominal",
          int'({warn, alarm}), 0);

    // R7: ALIGN three cycles after SYNC -> two apart
    req = "R7";
    cyc(1, 0, 3'b000, 0); idle(2); cyc(0, 0, 3'b000, 1);
    idle(16);
    check(warn === 1'b1, "R7", "warn two apart", int'(warn), 1);

    // R8: ALIGN five cycles after SYNC -> collision
    req = "R8";
    cyc(1, 0, 3'b000, 0); idle(4); cyc(0, 0, 3'b000, 1);
    idle(12);
    check(alarm === 1'b1, "R8", "alarm collision", int'(alarm), 1);

    // R9: periodic SYNC every DEPTH cycles
    req = "R9";
    cyc(1, 0, 3'b000, 1);
    idle(15);
    chk_seq = 1; prev_ok = 0;
    for (int k = 0; k < 5; k++) begin
      cyc(1, 0, 3'b000, 0);
      idle(DEPTH - 1);
    end
    chk_seq = 0;
    check(alarm === 1'b0 && warn === 1'b0, "R9", "flags after periodic SYNC",
          int'({warn, alarm}), 0);

    // R4: sync-only mode moves both pointers
    req = "R4";
    cyc(0, 1, 3'b001, 0); idle(6);
    wait_wpos(3);
    cyc(1, 0, 3'b000, 0);
    idle(16);
    check(alarm === 1'b0 && warn === 1'b0, "R4", "flags after sync-only",
          int'({warn, alarm}), 0);

    // R5: two-step software SYNC
    cyc(0, 1, 3'b010, 0); idle(3);
    req = "R5";
    wait_wpos(3);
    cyc(0, 1, 3'b110, 0);
    idle(16);

    // R6: software SYNC writes that must be ignored
    req = "R6";
    wait_wpos(3); cyc(0, 1, 3'b000, 0);
    wait_wpos(3); cyc(0, 1, 3'b100, 0);
    wait_wpos(3); cyc(0, 1, 3'b110, 0);
    idle(12);

    // R10: reset clears the sync-only bit
    cyc(0, 1, 3'b001, 0); idle(4);
    do_reset();
    req = "R10";
    cyc(1, 0, 3'b000, 0);
    idle(10);
    check(alarm === 1'b1, "R10", "read stuck after reset", int'(alarm), 1);
    check(rd_data === '0, "R10", "rd_data after reset", int'(rd_data), 0);
    finish_run();
  end
endmodule